// File: doc/BRIEF.md
# Pause Control Frame Builder

This block assembles a full-duplex flow-control request, one octet at a time, for a MAC transmit path. A request can come from host software or from a receive-buffer fill level crossing its threshold. On a request, the block takes a snapshot of the station address and the requested pause duration. It then streams a 60-octet frame: the reserved control multicast address, the station address, the MAC control EtherType, the pause opcode, the duration, and zero fill up to minimum length. The transmitter further down the path appends the four-octet frame check sequence, which makes the frame 64 octets on the wire.

The output is a valid/ready byte stream. A beat transfers on a rising clock edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, the block holds the byte and both markers unchanged. It never withdraws `tx_valid` before that beat has transferred. `tx_ready` may change in any cycle and does not need to wait for `tx_valid`. The request inputs are plain pins. Any cycle in which either one is high counts as a request.

Top module: `pause_frame_gen`

## Requirements
- R1: While reset is asserted and after it is released with no request, `tx_valid` is low.
- R2: When the block is idle, a request seen on either `host_req` or `wmark_req` at a clock edge starts a frame at that edge. `tx_valid` and `tx_sof` are high in the cycle that follows.
- R3: Every frame is exactly 60 transferred beats. `tx_sof` is high on the first beat only and `tx_eof` on the last beat only.
- R4: Beats 0 to 5 carry the destination 0x01, 0x80, 0xC2, 0x00, 0x00, 0x01 in that order.
- R5: Beats 6 to 11 carry the captured station address, most significant octet (bits 47:40) first.
- R6: Beats 12 to 15 carry 0x88, 0x08, 0x00, 0x01: the EtherType 0x8808 and then the opcode 0x0001, each high octet first.
- R7: Beats 16 and 17 carry the captured pause duration, bits 15:8 first.
- R8: Beats 18 to 59 are 0x00.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_sof` and `tx_eof` hold, and the frame does not advance.
- R10: A request made while a frame is in progress is held and served once that frame ends. Any number of such requests during one frame produce exactly one more frame. That frame starts with `tx_valid` low for exactly one cycle after the previous last beat transfers.
- R11: The station address and pause duration are sampled when the frame starts. Changes to them during the frame have no effect on that frame.
- R12: When nothing is pending, `tx_valid` falls in the cycle after the last beat transfers and stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Frame request from software |
| wmark_req | input | 1 | Frame request from the buffer-level threshold |
| station_addr | input | 48 | Own MAC address placed in the source field |
| pause_quanta | input | 16 | Pause duration in 512-bit-time units |
| tx_ready | input | 1 | Downstream can accept a beat |
| tx_valid | output | 1 | Beat on `tx_data` is valid |
| tx_data | output | 8 | Frame octet |
| tx_sof | output | 1 | First beat of the frame |
| tx_eof | output | 1 | Last beat of the frame |

## Verification
The bench builds the block with its default parameters: a 60-beat frame with the standard destination, EtherType and opcode. This puts the field boundaries at beats 6, 12, 16 and 18, the long zero tail, and the final beat 59 where `tx_eof` sits within reach of every frame. Four back-pressure patterns are used, from always ready to bursty stalls. Together they cover stalls on the first beat, on the last beat and on field boundaries. One frame has several requests stacked during it, to expose the one-cycle gap and the merging of requests.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  // Regions of the control frame, in wire order.
  typedef enum logic [2:0] {
    FLD_DST,
    FLD_SRC,
    FLD_TYPE,
    FLD_OPC,
    FLD_QNT,
    FLD_PAD
  } fld_e;

  // Start offsets of each region; fixed by the frame layout.
  localparam int unsigned OFS_SRC  = 6;
  localparam int unsigned OFS_TYPE = 12;
  localparam int unsigned OFS_OPC  = 14;
  localparam int unsigned OFS_QNT  = 16;
  localparam int unsigned OFS_PAD  = 18;

  function automatic fld_e field_of(input int unsigned pos);
    if (pos < OFS_SRC)       return FLD_DST;
    else if (pos < OFS_TYPE) return FLD_SRC;
    else if (pos < OFS_OPC)  return FLD_TYPE;
    else if (pos < OFS_QNT)  return FLD_OPC;
    else if (pos < OFS_PAD)  return FLD_QNT;
    else                     return FLD_PAD;
  endfunction

endpackage

// File: rtl/pfg_field_mux.sv
module pfg_field_mux
  import pfg_pkg::*;
#(
  parameter int unsigned IDX_W    = 6,
  parameter logic [47:0] DST_MAC  = 48'h0180C2000001,
  parameter logic [15:0] ETH_TYPE = 16'h8808,
  parameter logic [15:0] OPCODE   = 16'h0001
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [47:0]      src_q,
  input  logic [15:0]      qnt_q,
  output logic [7:0]       data
);

  int unsigned pos;
  assign pos = 32'(idx);

  always_comb begin
    data = 8'h00;
    unique case (field_of(pos))
      FLD_DST:  data = 8'(DST_MAC >> (8 * (OFS_SRC - 1 - pos)));
      FLD_SRC:  data = 8'(src_q >> (8 * (OFS_TYPE - 1 - pos)));
      FLD_TYPE: data = (pos == OFS_TYPE) ? ETH_TYPE[15:8] : ETH_TYPE[7:0];
      FLD_OPC:  data = (pos == OFS_OPC)  ? OPCODE[15:8]   : OPCODE[7:0];
      FLD_QNT:  data = (pos == OFS_QNT)  ? qnt_q[15:8]    : qnt_q[7:0];
      default:  data = 8'h00;
    endcase
  end

endmodule

// File: rtl/pfg_trigger.sv
module pfg_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  input  logic wmark_req,
  input  logic busy,
  output logic start
);

  logic pend_q;
  logic req_any;

  assign req_any = host_req | wmark_req;
  // Start as soon as the sequencer is free; a live request needs no latch cycle.
  assign start   = !busy && (pend_q || req_any);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (start) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_q | req_any;
    end
  end

endmodule

// File: rtl/pfg_sequencer.sv
module pfg_sequencer #(
  parameter int unsigned FRAME_BYTES = 60,
  parameter int unsigned IDX_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ready,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             first,
  output logic             last
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  logic adv;

  assign adv   = active && ready;
  assign first = active && (idx == '0);
  assign last  = active && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (adv) begin
      if (idx == LAST_IDX) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen #(
  parameter int unsigned FRAME_BYTES = 60,
  parameter logic [47:0] DST_MAC     = 48'h0180C2000001,
  parameter logic [15:0] ETH_TYPE    = 16'h8808,
  parameter logic [15:0] OPCODE      = 16'h0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        wmark_req,
  input  logic [47:0] station_addr,
  input  logic [15:0] pause_quanta,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_sof,
  output logic        tx_eof
);

  localparam int unsigned IDX_W = $clog2(FRAME_BYTES);

  logic             start;
  logic             active;
  logic [IDX_W-1:0] idx;
  logic [47:0]      src_q;
  logic [15:0]      qnt_q;

  pfg_trigger u_trigger (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_req  (host_req),
    .wmark_req (wmark_req),
    .busy      (active),
    .start     (start)
  );

  pfg_sequencer #(
    .FRAME_BYTES (FRAME_BYTES),
    .IDX_W       (IDX_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .ready  (tx_ready),
    .active (active),
    .idx    (idx),
    .first  (tx_sof),
    .last   (tx_eof)
  );

  // Snapshot of the frame's variable fields, taken only at frame start.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      qnt_q <= '0;
    end else if (start) begin
      src_q <= station_addr;
      qnt_q <= pause_quanta;
    end
  end

  pfg_field_mux #(
    .IDX_W    (IDX_W),
    .DST_MAC  (DST_MAC),
    .ETH_TYPE (ETH_TYPE),
    .OPCODE   (OPCODE)
  ) u_mux (
    .idx   (idx),
    .src_q (src_q),
    .qnt_q (qnt_q),
    .data  (tx_data)
  );

  assign tx_valid = active;

endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
  parameter int unsigned FRAME_BYTES = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_sof,
  input logic       tx_eof
);

  localparam int unsigned CNT_W = $clog2(FRAME_BYTES) + 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BYTES - 1);
  localparam logic [CNT_W-1:0] PAD_CNT  = CNT_W'(pfg_pkg::OFS_PAD);

  logic             hs;
  logic [CNT_W-1:0] beat_cnt;

  assign hs = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)           beat_cnt <= '0;
    else if (hs && tx_eof) beat_cnt <= '0;
    else if (hs)           beat_cnt <= beat_cnt + 1'b1;
  end

  a_r3_markers_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sof || tx_eof) |-> tx_valid);

  a_r3_sof_on_first: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && tx_sof) |-> (beat_cnt == '0));

  a_r3_eof_at_length: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && tx_eof) |-> (beat_cnt == LAST_CNT));

  a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && beat_cnt >= PAD_CNT) |-> (tx_data == 8'h00));

  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof)));

  a_r12_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && tx_eof) |=> !tx_valid);

endmodule

bind pause_frame_gen pfg_checker #(
  .FRAME_BYTES (FRAME_BYTES)
) u_pfg_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .tx_sof   (tx_sof),
  .tx_eof   (tx_eof)
);

// File: tb/test_pause_frame_gen.sv
module test_pause_frame_gen;

  localparam int FB = 60;
  localparam logic [47:0] DST = 48'h0180C2000001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        wmark_req = 1'b0;
  logic [47:0] station_addr = '0;
  logic [15:0] pause_quanta = '0;
  logic        tx_ready = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_sof;
  logic        tx_eof;

  pause_frame_gen i_pause_frame_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_req     (host_req),
    .wmark_req    (wmark_req),
    .station_addr (station_addr),
    .pause_quanta (pause_quanta),
    .tx_ready     (tx_ready),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_sof       (tx_sof),
    .tx_eof       (tx_eof)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [7:0] d;
    logic       s;
    logic       e;
  } beat_t;

  beat_t exp_q[$];
  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  int    bp_mode = 0;
  int    cyc = 0;
  int    pos = 0;
  bit    chk_gap = 0;
  bit    gap_arm = 0;
  int    idle_n = 0;
  bit    prev_stall = 0;
  logic [9:0] prev_beat = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard driver: expected beats computed from the frame layout.
  task automatic push_frame(input logic [47:0] s, input logic [15:0] q);
    for (int i = 0; i < FB; i++) begin
      beat_t b;
      if (i < 6)        b.d = 8'(DST >> (8 * (5 - i)));
      else if (i < 12)  b.d = 8'(s >> (8 * (11 - i)));
      else if (i == 12) b.d = 8'h88;
      else if (i == 13) b.d = 8'h08;
      else if (i == 14) b.d = 8'h00;
      else if (i == 15) b.d = 8'h01;
      else if (i == 16) b.d = q[15:8];
      else if (i == 17) b.d = q[7:0];
      else              b.d = 8'h00;
      b.s = (i == 0);
      b.e = (i == FB - 1);
      exp_q.push_back(b);
    end
  endtask

  task automatic pulse(input bit wm, input bit chk_start);
    @(posedge clk); #2;
    if (wm) wmark_req = 1'b1; else host_req = 1'b1;
    @(posedge clk); #2;
    wmark_req = 1'b0;
    host_req  = 1'b0;
    if (chk_start) begin
      @(negedge clk);
      check(tx_valid && tx_sof, "R2", "start one edge after request",
            {tx_valid, tx_sof}, 2'b11);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(negedge clk);
    check(!tx_valid, "R12", "valid low after last beat", tx_valid, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Back-pressure driver.
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      case (bp_mode)
        0:       tx_ready = 1'b1;
        1:       tx_ready = cyc[0];
        2:       tx_ready = (cyc % 5) != 0;
        default: tx_ready = (cyc % 7) < 3;
      endcase
    end
  end

  // Monitor: compare transferred beats against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall)
          check(tx_valid && {tx_data, tx_sof, tx_eof} == prev_beat, "R9",
                "beat held under stall", {tx_valid, tx_data, tx_sof, tx_eof},
                {1'b1, prev_beat});
        prev_stall = tx_valid && !tx_ready;
        prev_beat  = {tx_data, tx_sof, tx_eof};
        if (gap_arm) begin
          if (tx_valid) begin
            check(idle_n == 1, "R10", "idle cycles between frames", idle_n, 1);
            gap_arm = 0;
            chk_gap = 0;
          end else begin
            idle_n++;
          end
        end
        if (tx_valid && tx_ready) begin
          if (exp_q.size() == 0) begin
            check(0, "R10", "unexpected beat", tx_data, 0);
          end else begin
            beat_t e;
            string tag;
            e = exp_q.pop_front();
            if (pos < 6)       tag = "R4";
            else if (pos < 12) tag = "R5";
            else if (pos < 16) tag = "R6";
            else if (pos < 18) tag = "R7";
            else               tag = "R8";
            check(tx_data == e.d, tag, $sformatf("data beat %0d", pos), tx_data, e.d);
            check({tx_sof, tx_eof} == {e.s, e.e}, "R3",
                  $sformatf("markers beat %0d", pos), {tx_sof, tx_eof}, {e.s, e.e});
            pos = e.e ? 0 : pos + 1;
            if (e.e && chk_gap) begin
              gap_arm = 1;
              idle_n  = 0;
            end
          end
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!tx_valid, "R1", "valid low in reset", tx_valid, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!tx_valid, "R1", "valid low after reset", tx_valid, 0);

    // Host request, no back-pressure.
    bp_mode = 0;
    station_addr = 48'h0A1B2C3D4E5F;
    pause_quanta = 16'hFFFF;
    push_frame(station_addr, pause_quanta);
    pulse(1'b0, 1'b1);
    drain();

    // Watermark request, alternating ready.
    bp_mode = 1;
    station_addr = 48'hDEADBEEF0123;
    pause_quanta = 16'h1234;
    push_frame(station_addr, pause_quanta);
    pulse(1'b1, 1'b1);
    drain();

    // R11: inputs change mid-frame; the frame keeps the sampled values.
    bp_mode = 2;
    station_addr = 48'h112233445566;
    pause_quanta = 16'h00A5;
    push_frame(station_addr, pause_quanta);
    pulse(1'b0, 1'b0);
    repeat (10) @(posedge clk); #2;
    station_addr = 48'h998877665544;
    pause_quanta = 16'h5A00;
    drain();
    bp_mode = 3;
    push_frame(station_addr, pause_quanta);
    pulse(1'b1, 1'b0);
    drain();

    // R10: several requests during one frame merge into one follow-on frame.
    bp_mode = 0;
    station_addr = 48'hFFFFFFFFFFFF;
    pause_quanta = 16'h0000;
    push_frame(station_addr, pause_quanta);
    pulse(1'b0, 1'b0);
    repeat (20) @(posedge clk);
    push_frame(station_addr, pause_quanta);
    chk_gap = 1;
    pulse(1'b0, 1'b0);
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b0);
    drain();
    check(!chk_gap, "R10", "follow-on frame started", chk_gap, 0);

    // Stalled stream with a fresh frame.
    bp_mode = 3;
    station_addr = 48'h0000000000A0;
    pause_quanta = 16'h8001;
    push_frame(station_addr, pause_quanta);
    pulse(1'b1, 1'b0);
    drain();

    done = 1;
    summary();
    $finish;
  end

endmodule